// File: doc/BRIEF.md
# Dual-Port Synchronous RAM with Collision Resolution

This block is a behavioural model of a synchronous static RAM with two independent read/write ports, A and B, that share one clock. Each port has an active-low select, an active-low write strobe, an active-low per-bit write mask, an active-low output gate, an address, write data and read data. Reads are registered: the word at the address sampled on a rising edge appears on the read data output after that edge.

When both selected ports present the same address on the same edge, the block classifies the access pair and models its outcome. Two writes leave the word unknown: X is written and the word is marked poisoned. A write paired with a read completes normally, but the reading port's result is X and marked invalid. Two reads are legal and return correct data. A per-port `rd_bad` output marks invalid read data, whether it comes from a collision or from a poisoned word. A per-port `clash` output reports any collision that is not read/read.

Each port decodes its access mode on every edge. The modes are STANDBY (select high), READ (select low, write strobe high) and WRITE (select low, write strobe low). A port moves into whichever mode its inputs name on that edge, from any mode. The collision classifier uses five outcomes: NONE, READ_READ, A_WRITES_B_READS, A_READS_B_WRITES and WRITE_WRITE.

Top module: `dpram_collide`

## Requirements
- R1: A read (select low, write strobe high) places the stored word on read data after the rising edge that samples the address, with `rd_bad` low when the word is not poisoned.
- R2: Data bit i of the addressed word is written only when the port's write strobe is low and mask bit i is low; all other bits keep their value.
- R3: A write with every mask bit low replaces the whole word and clears its poison mark.
- R4: With the byte-mode parameter set, the mask input is one active-low enable per byte, and enable bit k controls data bits 8k to 8k+7.
- R5: A port with select high neither reads nor writes; its read data and `rd_bad` hold, and its `clash` output is low.
- R6: A collision exists only when both ports are selected and their addresses are equal on the same edge; a deselected port at the same address raises no collision.
- R7: On a write/write collision both `clash` outputs go high after the edge, and the word becomes poisoned: later reads return `rd_bad` high until a full-word write (R3) is made.
- R8: On a write/read collision the write completes, both `clash` outputs go high, and the reading port's `rd_bad` goes high for that read.
- R9: Two reads of the same address return correct data with both `clash` outputs low and both `rd_bad` low.
- R10: With the output gate high, a port's read data output is all zeros; with it low, the output shows the registered read data; `rd_bad` is not gated.
- R11: During and after reset, before any access, read data, `rd_bad` and `clash` are low on both ports, and no word is poisoned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of output registers and poison marks |
| a_sel_n | input | 1 | Port A select, active low |
| a_wr_n | input | 1 | Port A write strobe, active low |
| a_mask_n | input | MW | Port A write mask, active low (DW bits, or DW/8 in byte mode) |
| a_oe_n | input | 1 | Port A output gate, active low |
| a_addr | input | AW | Port A address |
| a_wdata | input | DW | Port A write data |
| a_rdata | output | DW | Port A read data |
| a_rd_bad | output | 1 | Port A read data invalid |
| a_clash | output | 1 | Port A collision flag |
| b_sel_n | input | 1 | Port B select, active low |
| b_wr_n | input | 1 | Port B write strobe, active low |
| b_mask_n | input | MW | Port B write mask, active low |
| b_oe_n | input | 1 | Port B output gate, active low |
| b_addr | input | AW | Port B address |
| b_wdata | input | DW | Port B write data |
| b_rdata | output | DW | Port B read data |
| b_rd_bad | output | 1 | Port B read data invalid |
| b_clash | output | 1 | Port B collision flag |

## Verification
The hardest situation to reach is a poisoned word that survives a later partial write. It needs a write/write collision on one edge, then a masked write that leaves some bits untouched, then a read. Only after that is a full-word write expected to clear the mark. The stimulus builds this chain on one address. A sweep then drives every pairing of STANDBY, READ and WRITE on the two ports, at equal and at unequal addresses. For each pairing it predicts the flags, the invalid-read marks and the memory contents arithmetically, including the selected/deselected pairs at equal addresses.

// File: rtl/dpc_pkg.sv
`timescale 1ns/1ps
package dpc_pkg;
    typedef enum logic [1:0] {
        ACC_STBY  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } acc_e;

    typedef enum logic [2:0] {
        CL_NONE     = 3'd0,
        CL_RR       = 3'd1,
        CL_AW_BR    = 3'd2,
        CL_AR_BW    = 3'd3,
        CL_WW       = 3'd4
    } clash_e;
endpackage

// File: rtl/dpc_port.sv
`timescale 1ns/1ps
module dpc_port
    import dpc_pkg::*;
#(
    parameter int DW        = 32,
    parameter bit BYTE_MODE = 1'b0,
    parameter int MW        = DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel_n,
    input  logic          wr_n,
    input  logic [MW-1:0] mask_n,
    input  logic          oe_n,
    input  logic [DW-1:0] arr_word,
    input  logic          arr_poison,
    input  logic          kill,
    input  logic          clash_in,
    output acc_e          acc,
    output logic [DW-1:0] bit_en,
    output logic [DW-1:0] rdata,
    output logic          rd_bad,
    output logic          clash_flag
);
    logic [DW-1:0] rdata_q;
    logic          bad_q;
    logic          clash_q;
    logic          wr_go;

    // access mode decode
    always_comb begin
        unique case ({sel_n, wr_n})
            2'b00:   acc = ACC_WRITE;
            2'b01:   acc = ACC_READ;
            default: acc = ACC_STBY;
        endcase
    end

    assign wr_go = (acc == ACC_WRITE);

    // mask expansion: per bit, or one enable per byte
    if (BYTE_MODE) begin : g_byte
        for (genvar k = 0; k < MW; k++) begin : g_lane
            assign bit_en[8*k +: 8] = {8{wr_go & ~mask_n[k]}};
        end
    end else begin : g_bit
        assign bit_en = {DW{wr_go}} & ~mask_n;
    end

    // output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
            bad_q   <= 1'b0;
            clash_q <= 1'b0;
        end else begin
            clash_q <= clash_in;
            unique case (acc)
                ACC_READ: begin
                    rdata_q <= kill ? {DW{1'bx}} : arr_word;
                    bad_q   <= kill | arr_poison;
                end
                default: ;
            endcase
        end
    end

    assign rdata      = oe_n ? '0 : rdata_q;
    assign rd_bad     = bad_q;
    assign clash_flag = clash_q;

    // R5: a deselected port keeps its read result and reports no collision
    a_r5_standby_hold: assert property (@(posedge clk) disable iff (!rst_n)
        sel_n |=> ($stable(rdata_q) && $stable(bad_q) && !clash_q));

    // R8: a read killed by a collision is reported invalid
    a_r8_killed_read_bad: assert property (@(posedge clk) disable iff (!rst_n)
        (acc == ACC_READ && kill) |=> bad_q);
endmodule

// File: rtl/dpc_clash.sv
`timescale 1ns/1ps
module dpc_clash
    import dpc_pkg::*;
#(
    parameter int AW = 8
) (
    input  acc_e          acc_a,
    input  acc_e          acc_b,
    input  logic [AW-1:0] addr_a,
    input  logic [AW-1:0] addr_b,
    output logic          kill_a,
    output logic          kill_b,
    output logic          ww,
    output logic          flag
);
    clash_e kind;

    always_comb begin
        kind = CL_NONE;
        if (acc_a != ACC_STBY && acc_b != ACC_STBY && addr_a == addr_b) begin
            unique case ({acc_a == ACC_WRITE, acc_b == ACC_WRITE})
                2'b00: kind = CL_RR;
                2'b10: kind = CL_AW_BR;
                2'b01: kind = CL_AR_BW;
                2'b11: kind = CL_WW;
            endcase
        end
    end

    assign kill_a = (kind == CL_AR_BW);
    assign kill_b = (kind == CL_AW_BR);
    assign ww     = (kind == CL_WW);
    assign flag   = (kind == CL_AW_BR) || (kind == CL_AR_BW) || (kind == CL_WW);
endmodule

// File: rtl/dpc_array.sv
`timescale 1ns/1ps
module dpc_array #(
    parameter int DW = 32,
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_a,
    input  logic          wr_b,
    input  logic [AW-1:0] addr_a,
    input  logic [AW-1:0] addr_b,
    input  logic [DW-1:0] wd_a,
    input  logic [DW-1:0] wd_b,
    input  logic [DW-1:0] en_a,
    input  logic [DW-1:0] en_b,
    input  logic          ww,
    output logic [DW-1:0] word_a,
    output logic [DW-1:0] word_b,
    output logic          poison_a,
    output logic          poison_b
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0]    mem [DEPTH];
    logic [DEPTH-1:0] poison_q;

    always_ff @(posedge clk) begin
        if (ww) begin
            mem[addr_a] <= {DW{1'bx}};
        end else begin
            if (wr_a) mem[addr_a] <= (mem[addr_a] & ~en_a) | (wd_a & en_a);
            if (wr_b) mem[addr_b] <= (mem[addr_b] & ~en_b) | (wd_b & en_b);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            poison_q <= '0;
        end else if (ww) begin
            poison_q[addr_a] <= 1'b1;
        end else begin
            if (wr_a && (&en_a)) poison_q[addr_a] <= 1'b0;
            if (wr_b && (&en_b)) poison_q[addr_b] <= 1'b0;
        end
    end

    assign word_a   = mem[addr_a];
    assign word_b   = mem[addr_b];
    assign poison_a = poison_q[addr_a];
    assign poison_b = poison_q[addr_b];

    // R7: a double write leaves the word poisoned
    a_r7_ww_poisons: assert property (@(posedge clk) disable iff (!rst_n)
        ww |=> poison_q[$past(addr_a)]);

    // R3: a lone full-word write clears the poison mark
    a_r3_full_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_a && (&en_a) && !ww) |=> !poison_q[$past(addr_a)]);
endmodule

// File: rtl/dpram_collide.sv
`timescale 1ns/1ps
module dpram_collide
    import dpc_pkg::*;
#(
    parameter int  DW        = 32,
    parameter int  AW        = 8,
    parameter bit  BYTE_MODE = 1'b0,
    localparam int MW        = BYTE_MODE ? DW / 8 : DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          a_sel_n,
    input  logic          a_wr_n,
    input  logic [MW-1:0] a_mask_n,
    input  logic          a_oe_n,
    input  logic [AW-1:0] a_addr,
    input  logic [DW-1:0] a_wdata,
    output logic [DW-1:0] a_rdata,
    output logic          a_rd_bad,
    output logic          a_clash,
    input  logic          b_sel_n,
    input  logic          b_wr_n,
    input  logic [MW-1:0] b_mask_n,
    input  logic          b_oe_n,
    input  logic [AW-1:0] b_addr,
    input  logic [DW-1:0] b_wdata,
    output logic [DW-1:0] b_rdata,
    output logic          b_rd_bad,
    output logic          b_clash
);
    acc_e          acc_a, acc_b;
    logic [DW-1:0] en_a, en_b, word_a, word_b;
    logic          poison_a, poison_b, kill_a, kill_b, ww, flag;

    dpc_port #(.DW(DW), .BYTE_MODE(BYTE_MODE), .MW(MW)) port_a_i (
        .clk(clk), .rst_n(rst_n), .sel_n(a_sel_n), .wr_n(a_wr_n),
        .mask_n(a_mask_n), .oe_n(a_oe_n), .arr_word(word_a),
        .arr_poison(poison_a), .kill(kill_a), .clash_in(flag),
        .acc(acc_a), .bit_en(en_a), .rdata(a_rdata), .rd_bad(a_rd_bad),
        .clash_flag(a_clash)
    );

    dpc_port #(.DW(DW), .BYTE_MODE(BYTE_MODE), .MW(MW)) port_b_i (
        .clk(clk), .rst_n(rst_n), .sel_n(b_sel_n), .wr_n(b_wr_n),
        .mask_n(b_mask_n), .oe_n(b_oe_n), .arr_word(word_b),
        .arr_poison(poison_b), .kill(kill_b), .clash_in(flag),
        .acc(acc_b), .bit_en(en_b), .rdata(b_rdata), .rd_bad(b_rd_bad),
        .clash_flag(b_clash)
    );

    dpc_clash #(.AW(AW)) clash_i (
        .acc_a(acc_a), .acc_b(acc_b), .addr_a(a_addr), .addr_b(b_addr),
        .kill_a(kill_a), .kill_b(kill_b), .ww(ww), .flag(flag)
    );

    dpc_array #(.DW(DW), .AW(AW)) array_i (
        .clk(clk), .rst_n(rst_n),
        .wr_a(acc_a == ACC_WRITE), .wr_b(acc_b == ACC_WRITE),
        .addr_a(a_addr), .addr_b(b_addr), .wd_a(a_wdata), .wd_b(b_wdata),
        .en_a(en_a), .en_b(en_b), .ww(ww),
        .word_a(word_a), .word_b(word_b),
        .poison_a(poison_a), .poison_b(poison_b)
    );

    // R7: two writes to one address flag both ports
    a_r7_ww_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (!a_sel_n && !b_sel_n && !a_wr_n && !b_wr_n && a_addr == b_addr)
        |=> (a_clash && b_clash));

    // R9: two reads of one address raise no flag
    a_r9_rr_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (!a_sel_n && !b_sel_n && a_wr_n && b_wr_n && a_addr == b_addr)
        |=> (!a_clash && !b_clash));

    // R6: a deselected port takes part in no collision
    a_r6_desel_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (a_sel_n || b_sel_n) |=> (!a_clash && !b_clash));

    // R8: B reading while A writes the same word invalidates B's read
    a_r8_reader_bad: assert property (@(posedge clk) disable iff (!rst_n)
        (!a_sel_n && !b_sel_n && !a_wr_n && b_wr_n && a_addr == b_addr)
        |=> (b_rd_bad && a_clash && b_clash));
endmodule

// File: tb/dpram_collide_tb.sv
`timescale 1ns/1ps
module dpram_collide_tb_top;
    localparam int DW = 16;
    localparam int AW = 4;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic          a_sel_n, a_wr_n, a_oe_n, b_sel_n, b_wr_n, b_oe_n;
    logic [DW-1:0] a_mask_n, b_mask_n, a_wdata, b_wdata, a_rdata, b_rdata;
    logic [AW-1:0] a_addr, b_addr;
    logic          a_rd_bad, b_rd_bad, a_clash, b_clash;

    logic          y_sel_n, y_wr_n;
    logic [1:0]    y_be_n;
    logic [AW-1:0] y_addr;
    logic [DW-1:0] y_wdata, y_rdata, yb_rdata;
    logic          y_bad, y_clash, yb_bad, yb_clash;

    dpram_collide #(.DW(DW), .AW(AW), .BYTE_MODE(1'b0)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .a_sel_n(a_sel_n), .a_wr_n(a_wr_n), .a_mask_n(a_mask_n), .a_oe_n(a_oe_n),
        .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(a_rdata),
        .a_rd_bad(a_rd_bad), .a_clash(a_clash),
        .b_sel_n(b_sel_n), .b_wr_n(b_wr_n), .b_mask_n(b_mask_n), .b_oe_n(b_oe_n),
        .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(b_rdata),
        .b_rd_bad(b_rd_bad), .b_clash(b_clash)
    );

    dpram_collide #(.DW(DW), .AW(AW), .BYTE_MODE(1'b1)) dut_byte_i (
        .clk(clk), .rst_n(rst_n),
        .a_sel_n(y_sel_n), .a_wr_n(y_wr_n), .a_mask_n(y_be_n), .a_oe_n(1'b0),
        .a_addr(y_addr), .a_wdata(y_wdata), .a_rdata(y_rdata),
        .a_rd_bad(y_bad), .a_clash(y_clash),
        .b_sel_n(1'b1), .b_wr_n(1'b1), .b_mask_n(2'b11), .b_oe_n(1'b0),
        .b_addr('0), .b_wdata('0), .b_rdata(yb_rdata),
        .b_rd_bad(yb_bad), .b_clash(yb_clash)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;
    logic [DW-1:0] ref_mem [DEPTH];
    bit            ref_poi [DEPTH];

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        a_sel_n = 1'b1; a_wr_n = 1'b1; a_mask_n = '1; a_addr = '0; a_wdata = '0;
        b_sel_n = 1'b1; b_wr_n = 1'b1; b_mask_n = '1; b_addr = '0; b_wdata = '0;
    endtask

    function automatic logic [DW-1:0] pat(input int a, input int k);
        return DW'(a * 16'h1357 + k * 16'h0F1D) ^ 16'hA5C3;
    endfunction

    // mode: 0 standby, 1 read, 2 write (full mask)
    task automatic drive_a(input int mode, input int ad, input logic [DW-1:0] d, input logic [DW-1:0] mn);
        a_sel_n = (mode == 0); a_wr_n = (mode != 2); a_addr = AW'(ad);
        a_wdata = d; a_mask_n = mn;
    endtask

    task automatic drive_b(input int mode, input int ad, input logic [DW-1:0] d, input logic [DW-1:0] mn);
        b_sel_n = (mode == 0); b_wr_n = (mode != 2); b_addr = AW'(ad);
        b_wdata = d; b_mask_n = mn;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        idle();
        a_oe_n = 1'b0; b_oe_n = 1'b0;
        y_sel_n = 1'b1; y_wr_n = 1'b1; y_be_n = 2'b11; y_addr = '0; y_wdata = '0;
        repeat (3) @(negedge clk);

        // R11: reset state
        chk("R11 a_rdata", 32'(a_rdata), 0);
        chk("R11 b_rdata", 32'(b_rdata), 0);
        chk("R11 flags", {a_rd_bad, b_rd_bad, a_clash, b_clash}, 0);
        rst_n = 1'b1;
        step();
        chk("R11 after release", {a_rd_bad, b_rd_bad, a_clash, b_clash, y_bad}, 0);

        // R3: fill every word with full-mask writes from port A
        for (int i = 0; i < DEPTH; i++) begin
            drive_a(2, i, pat(i, 0), '0);
            step();
            ref_mem[i] = pat(i, 0);
            ref_poi[i] = 1'b0;
        end
        idle();

        // R1: read sweep on both ports, distinct addresses
        for (int i = 0; i < DEPTH; i++) begin
            drive_a(1, i, '0, '0);
            drive_b(1, DEPTH - 1 - i, '0, '0);
            step();
            chk("R1 a read", 32'(a_rdata), 32'(ref_mem[i]));
            chk("R1 b read", 32'(b_rdata), 32'(ref_mem[DEPTH-1-i]));
            chk("R1 clean flags", {a_rd_bad, b_rd_bad, a_clash, b_clash}, 0);
        end
        idle();

        // R2: masked writes, mask pattern varies by address
        for (int i = 0; i < DEPTH; i++) begin
            logic [DW-1:0] mn;
            mn = pat(i, 2);
            drive_a(2, i, pat(i, 1), mn);
            step();
            ref_mem[i] = (ref_mem[i] & mn) | (pat(i, 1) & ~mn);
        end
        idle();
        for (int i = 0; i < DEPTH; i++) begin
            drive_b(1, i, 16'hFFFF, '0);
            step();
            chk("R2 masked content", 32'(b_rdata), 32'(ref_mem[i]));
        end
        idle();

        // R5/R6: deselected port at same address with write asserted
        drive_b(1, 2, '0, '0);
        step();
        chk("R5 setup read", 32'(b_rdata), 32'(ref_mem[2]));
        drive_b(2, 2, ~ref_mem[2], '0);
        b_sel_n = 1'b1;
        drive_a(1, 2, '0, '0);
        step();
        chk("R5 rdata held", 32'(b_rdata), 32'(ref_mem[2]));
        chk("R6 no clash", {a_clash, b_clash}, 0);
        chk("R6 a read ok", {a_rd_bad, 16'(a_rdata)}, {1'b0, ref_mem[2]});
        drive_a(2, 3, pat(3, 9), '0);
        step();
        ref_mem[3] = pat(3, 9);
        chk("R6 write vs deselected", {a_clash, b_clash}, 0);
        idle();
        drive_b(1, 2, '0, '0);
        step();
        chk("R5 no write in standby", 32'(b_rdata), 32'(ref_mem[2]));
        idle();

        // R8: A writes, B reads same word
        drive_a(2, 5, pat(5, 3), '0);
        drive_b(1, 5, '0, '0);
        step();
        ref_mem[5] = pat(5, 3);
        chk("R8 b_rd_bad", b_rd_bad, 1);
        chk("R8 both clash", {a_clash, b_clash}, 2'b11);
        idle();
        drive_b(1, 5, '0, '0);
        step();
        chk("R8 write completed", {b_rd_bad, 16'(b_rdata)}, {1'b0, ref_mem[5]});
        // R8 reversed: B partial write, A reads
        drive_b(2, 6, pat(6, 4), 16'hF0F0);
        drive_a(1, 6, '0, '0);
        step();
        ref_mem[6] = (ref_mem[6] & 16'hF0F0) | (pat(6, 4) & 16'h0F0F);
        chk("R8 a_rd_bad", a_rd_bad, 1);
        chk("R8 both clash rev", {a_clash, b_clash}, 2'b11);
        idle();
        drive_a(1, 6, '0, '0);
        step();
        chk("R8 rev write completed", {a_rd_bad, 16'(a_rdata)}, {1'b0, ref_mem[6]});

        // R9: read/read same address
        drive_a(1, 7, '0, '0);
        drive_b(1, 7, '0, '0);
        step();
        chk("R9 a data", {a_rd_bad, 16'(a_rdata)}, {1'b0, ref_mem[7]});
        chk("R9 b data", {b_rd_bad, 16'(b_rdata)}, {1'b0, ref_mem[7]});
        chk("R9 no clash", {a_clash, b_clash}, 0);
        idle();

        // R7: write/write poisons until full write
        drive_a(2, 9, pat(9, 5), '0);
        drive_b(2, 9, pat(9, 6), '0);
        step();
        chk("R7 both clash", {a_clash, b_clash}, 2'b11);
        idle();
        drive_a(1, 9, '0, '0);
        step();
        chk("R7 poisoned read", a_rd_bad, 1);
        drive_a(2, 9, pat(9, 7), 16'h00FF);
        step();
        drive_a(1, 9, '0, '0);
        step();
        chk("R7 partial keeps poison", a_rd_bad, 1);
        drive_a(2, 9, pat(9, 8), '0);
        step();
        ref_mem[9] = pat(9, 8);
        drive_a(1, 9, '0, '0);
        step();
        chk("R7 full write clears", {a_rd_bad, 16'(a_rdata)}, {1'b0, ref_mem[9]});
        idle();

        // R10: output gate
        drive_a(1, 4, '0, '0);
        step();
        idle();
        a_oe_n = 1'b1;
        #1;
        chk("R10 gated zero", 32'(a_rdata), 0);
        chk("R10 bad ungated", a_rd_bad, 0);
        a_oe_n = 1'b0;
        #1;
        chk("R10 ungated data", 32'(a_rdata), 32'(ref_mem[4]));

        // R6/R7/R8/R9: sweep every mode pair, equal and unequal addresses
        for (int eq = 0; eq < 2; eq++) begin
            for (int ka = 0; ka < 3; ka++) begin
                for (int kb = 0; kb < 3; kb++) begin
                    int aa, ab;
                    bit coll, ea_bad, eb_bad;
                    logic [DW-1:0] da, db;
                    aa = 10; ab = (eq == 1) ? 10 : 11;
                    da = pat(ka * 3 + kb, 5); db = pat(ka * 3 + kb, 6);
                    drive_a(ka, aa, da, '0);
                    drive_b(kb, ab, db, '0);
                    step();
                    coll = (ka != 0) && (kb != 0) && (eq == 1) && ((ka == 2) || (kb == 2));
                    chk("R6 sweep clash", {a_clash, b_clash}, {coll, coll});
                    ea_bad = ((eq == 1) && (kb == 2)) || ref_poi[aa];
                    eb_bad = ((eq == 1) && (ka == 2)) || ref_poi[ab];
                    if (ka == 1) begin
                        chk("R8 sweep a bad", a_rd_bad, ea_bad);
                        if (!ea_bad) chk("R9 sweep a data", 32'(a_rdata), 32'(ref_mem[aa]));
                    end
                    if (kb == 1) begin
                        chk("R8 sweep b bad", b_rd_bad, eb_bad);
                        if (!eb_bad) chk("R9 sweep b data", 32'(b_rdata), 32'(ref_mem[ab]));
                    end
                    if (ka == 2 && kb == 2 && eq == 1) begin
                        ref_poi[aa] = 1'b1;
                    end else begin
                        if (ka == 2) begin ref_mem[aa] = da; ref_poi[aa] = 1'b0; end
                        if (kb == 2) begin ref_mem[ab] = db; ref_poi[ab] = 1'b0; end
                    end
                end
            end
        end
        idle();

        // R4: byte-granular enables, byte k covers bits 8k..8k+7
        y_sel_n = 1'b0; y_wr_n = 1'b0; y_be_n = 2'b00; y_addr = 4'd1; y_wdata = 16'h1234;
        step();
        y_be_n = 2'b10; y_wdata = 16'hABCD;
        step();
        y_wr_n = 1'b1;
        step();
        chk("R4 low byte only", 32'(y_rdata), 32'h12CD);
        y_wr_n = 1'b0; y_be_n = 2'b01; y_wdata = 16'h5678;
        step();
        y_wr_n = 1'b1;
        step();
        chk("R4 high byte only", 32'(y_rdata), 32'h56CD);
        y_sel_n = 1'b1;

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule